// File: doc/BRIEF.md
# SCSI Selection Detection Interrupt

This block watches a SCSI bus for a selection attempt aimed at the local device. The CPU loads an 8-bit ID mask, where each set bit names a data bus line that counts as "our" ID. The block flags a selection when three things hold together: one of the masked ID lines is asserted, BSY is released and SEL is asserted. It then raises a sticky interrupt that software clears with a one-cycle pulse. Writing a mask of zero turns the interrupt off. There is no separate enable bit. A reset loads a zero mask, so detection stays off until software writes one.

All bus pins are active low and reach the block unsynchronized. Each pin passes through a synchronizer chain. A hold stage follows the chain, and the combined bus pattern must read the same in two samples in a row before it is judged. This keeps a skewed bus from producing a false match. When parity checking is enabled, the block checks the data bus and its parity line at the moment a selection is detected, using odd parity. A failed check sets a parity-error flag together with the interrupt.

Top module: `sel_watch`

## Requirements
- R1: After reset, `sel_irq` and `par_err` are 0 and the ID mask is 0.
- R2: A cycle with `mask_we` high loads `mask_wdata` into the mask, and the new mask is used from the next cycle onward. While the mask is zero, `sel_irq` never rises.
- R3: A selection is detected when every one of these holds at once: (~`db_n` & mask) is non-zero, `bsy_n` = 1 and `sel_n` = 0. Detection sets `sel_irq` to 1.
- R4: No selection is detected if `bsy_n` = 0, or if `sel_n` = 1, or if no asserted ID line (a `db_n` bit at 0) falls under a mask bit.
- R5: Suppose the bus inputs change before clock edge 1 and then hold. `sel_irq` stays unchanged through edge 3 and shows the result after edge 4. That is two synchronizer flops, one stability sample, then the interrupt register.
- R6: The interrupt fires on the rising edge of the detection condition only. `sel_irq` stays 1 until `irq_clr` is pulsed. A selection that is held after a clear does not raise the interrupt again.
- R7: `irq_clr` clears both `sel_irq` and `par_err` on the next edge. If a new detection edge falls in the same cycle as the clear, the new detection wins and `sel_irq` (and `par_err` if that event has a parity fault) read 1.
- R8: Parity is odd over the eight asserted-level data bits plus the asserted-level parity bit (~`dbp_n`). If `par_chk_en` = 1 when a selection is detected and the XOR of those nine bits is 0, `par_err` is set in the same cycle as `sel_irq`.
- R9: With `par_chk_en` = 0, `par_err` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Value written to the ID mask |
| db_n | input | 8 | SCSI data bus, active low |
| dbp_n | input | 1 | SCSI data parity, active low |
| bsy_n | input | 1 | SCSI BSY, active low |
| sel_n | input | 1 | SCSI SEL, active low |
| par_chk_en | input | 1 | Enables the parity check at selection |
| irq_clr | input | 1 | One-cycle pulse that clears the interrupt and error flags |
| sel_irq | output | 1 | Sticky selection interrupt |
| par_err | output | 1 | Sticky parity-error flag |

## Verification
A software clear and a new selection edge can land on the same clock edge, and the two act on the same flag in opposite directions. The bench first leaves an older interrupt pending and releases the bus. It then drives a fresh selection and times the `irq_clr` pulse so that it meets the edge on which the synchronized condition first becomes true. The expected result is that `sel_irq` stays 1 across that edge, because the new detection takes priority over the clear.

// File: rtl/sel_watch_pkg.sv
package sel_watch_pkg;
  // Bit positions inside the raw bus vector handed through the synchronizer
  localparam int unsigned BIT_SEL  = 0;
  localparam int unsigned BIT_BSY  = 1;
  localparam int unsigned BIT_PAR  = 2;
  localparam int unsigned BIT_ID0  = 3;

  // Odd parity holds when the XOR of data and parity (asserted levels) is 1
  function automatic logic odd_ok(input logic [7:0] id, input logic par);
    return ^{id, par};
  endfunction
endpackage

// File: rtl/sel_watch_sync.sv
module sel_watch_sync #(
  parameter int unsigned W      = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         stable
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] hold_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g] <= '1;
      else if (g == 0) chain[g] <= d;
      else chain[g] <= chain[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '1;
    else        hold_q <= chain[STAGES-1];
  end

  assign q      = hold_q;
  assign stable = (hold_q == chain[STAGES-1]);

  // R5: the judged value equals the last synchronizer sample one cycle back
  AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (q == $past(chain[STAGES-1]))); // R5
endmodule

// File: rtl/sel_watch_mask.sv
module sel_watch_mask #(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [ID_W-1:0] wdata,
  output logic [ID_W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)  mask <= '0;
    else if (we) mask <= wdata;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mask == $past(wdata))); // R2
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask)); // R2
endmodule

// File: rtl/sel_watch_detect.sv
module sel_watch_detect #(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] id,
  input  logic            par,
  input  logic            bsy,
  input  logic            sel,
  input  logic            stable,
  input  logic [ID_W-1:0] mask,
  input  logic            par_chk_en,
  input  logic            irq_clr,
  output logic            sel_irq,
  output logic            par_err
);
  import sel_watch_pkg::*;

  logic cond, cond_q, fresh, bad_par;

  assign cond    = stable && sel && !bsy && ((id & mask) != '0);
  assign fresh   = cond && !cond_q;
  assign bad_par = par_chk_en && !odd_ok(id, par);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q  <= 1'b0;
      sel_irq <= 1'b0;
      par_err <= 1'b0;
    end else begin
      cond_q <= cond;
      if (fresh) begin
        sel_irq <= 1'b1;
        par_err <= bad_par | (par_err & ~irq_clr);
      end else if (irq_clr) begin
        sel_irq <= 1'b0;
        par_err <= 1'b0;
      end
    end
  end

  AST_RISE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_irq) |-> $past(stable && sel && !bsy && ((id & mask) != '0))); // R3
  AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> !$rose(sel_irq)); // R2
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_irq && !irq_clr) |=> sel_irq); // R6
  AST_PERR_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> sel_irq); // R8
  AST_PERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> $past(par_chk_en)); // R9
endmodule

// File: rtl/sel_watch.sv
module sel_watch #(
  parameter int unsigned ID_W        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic [ID_W-1:0] mask_wdata,
  input  logic [ID_W-1:0] db_n,
  input  logic            dbp_n,
  input  logic            bsy_n,
  input  logic            sel_n,
  input  logic            par_chk_en,
  input  logic            irq_clr,
  output logic            sel_irq,
  output logic            par_err
);
  import sel_watch_pkg::*;

  localparam int unsigned BUS_W = ID_W + BIT_ID0;

  logic [BUS_W-1:0] raw_n, sync_n;
  logic             stable;
  logic [ID_W-1:0]  mask;

  assign raw_n = {db_n, dbp_n, bsy_n, sel_n};

  sel_watch_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_n), .q(sync_n), .stable(stable)
  );

  sel_watch_mask #(.ID_W(ID_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(mask_wdata), .mask(mask)
  );

  sel_watch_detect #(.ID_W(ID_W)) u_detect (
    .clk(clk), .rst_n(rst_n),
    .id(~sync_n[BUS_W-1:BIT_ID0]),
    .par(~sync_n[BIT_PAR]),
    .bsy(~sync_n[BIT_BSY]),
    .sel(~sync_n[BIT_SEL]),
    .stable(stable), .mask(mask),
    .par_chk_en(par_chk_en), .irq_clr(irq_clr),
    .sel_irq(sel_irq), .par_err(par_err)
  );
endmodule

// File: tb/sel_watch_test.sv
`timescale 1ns/1ps
module sel_watch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic [7:0] db_n = 8'hFF;
  logic       dbp_n = 1'b1;
  logic       bsy_n = 1'b1;
  logic       sel_n = 1'b1;
  logic       par_chk_en = 1'b0;
  logic       irq_clr = 1'b0;
  logic       sel_irq, par_err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sel_watch uut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<100000", cyc);
      summary();
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic exp_sel(input logic [7:0] m, input logic [7:0] dn,
                                   input logic bn, input logic sn);
    return ((~dn & m) != 8'h00) && bn && !sn;
  endfunction

  function automatic logic exp_perr(input logic [7:0] m, input logic [7:0] dn,
                                    input logic pn, input logic bn, input logic sn,
                                    input logic en);
    return exp_sel(m, dn, bn, sn) && en && !(^{~dn, ~pn});
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_mask(input logic [7:0] v);
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = v;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic idle_bus();
    @(negedge clk);
    db_n = 8'hFF; dbp_n = 1'b1; bsy_n = 1'b1; sel_n = 1'b1;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  logic [7:0] m;
  logic e_s, e_p;

  initial begin
    void'($urandom(32'h5E1EC7));
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    check("R1 sel_irq after reset", sel_irq, 1'b0);
    check("R1 par_err after reset", par_err, 1'b0);
    // R1/R2: mask is zero after reset, so a full selection does nothing
    db_n = 8'h00; dbp_n = 1'b0; bsy_n = 1'b1; sel_n = 1'b0;
    cycles(8);
    check("R1 R2 zero mask blocks selection", sel_irq, 1'b0);
    idle_bus(); cycles(6);

    // R5 exact latency
    write_mask(8'h04);
    par_chk_en = 1'b0;
    db_n = 8'hFB; dbp_n = 1'b1; bsy_n = 1'b1; sel_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R5 no interrupt through edge 3", sel_irq, 1'b0);
    @(posedge clk);
    #1 check("R5 interrupt after edge 4", sel_irq, 1'b1);
    // R6 held selection after clear does not re-fire
    cycles(4);
    pulse_clr(); cycles(6);
    check("R6 no refire on held selection", sel_irq, 1'b0);
    // R4 BSY asserted blocks
    idle_bus(); cycles(6);
    db_n = 8'hFB; bsy_n = 1'b0; sel_n = 1'b0;
    cycles(8);
    check("R4 BSY asserted blocks", sel_irq, 1'b0);
    // R4 unmasked ID line only
    idle_bus(); cycles(6);
    db_n = 8'hFE; sel_n = 1'b0;
    cycles(8);
    check("R4 unmasked ID ignored", sel_irq, 1'b0);

    // R7 clear and new rise in the same cycle: rise wins
    db_n = 8'hFB; cycles(8);
    check("R7 setup pending interrupt", sel_irq, 1'b1);
    idle_bus(); cycles(6);
    db_n = 8'hFB; sel_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); irq_clr = 1'b1;
    @(posedge clk);
    #1 check("R7 new detection beats clear", sel_irq, 1'b1);
    @(negedge clk); irq_clr = 1'b0;
    pulse_clr(); cycles(1);
    check("R7 plain clear drops flag", sel_irq, 1'b0);

    // R8 / R9 parity
    idle_bus(); cycles(6);
    par_chk_en = 1'b1;
    db_n = 8'hFB; dbp_n = 1'b1; sel_n = 1'b0;   // one data bit, parity off -> odd ok
    cycles(8);
    check("R8 good parity no error", par_err, 1'b0);
    idle_bus(); pulse_clr(); cycles(6);
    db_n = 8'hFB; dbp_n = 1'b0; sel_n = 1'b0;   // two bits asserted -> even -> error
    cycles(8);
    check("R8 bad parity sets error", par_err, 1'b1);
    check("R8 error comes with interrupt", sel_irq, 1'b1);
    pulse_clr(); cycles(1);
    check("R7 clear drops par_err", par_err, 1'b0);
    idle_bus(); cycles(6);
    par_chk_en = 1'b0;
    db_n = 8'hFB; dbp_n = 1'b0; sel_n = 1'b0;
    cycles(8);
    check("R9 bad parity ignored when disabled", par_err, 1'b0);
    idle_bus(); pulse_clr(); cycles(6);

    // Random patterns (R2 R3 R4 R8 R9 R6)
    for (int i = 0; i < 60; i++) begin
      m = ($urandom % 5 == 0) ? 8'h00 : 8'($urandom);
      write_mask(m);
      par_chk_en = 1'($urandom);
      db_n  = ($urandom % 3 == 0) ? ~(8'h01 << ($urandom % 8)) : 8'($urandom);
      dbp_n = 1'($urandom);
      bsy_n = ($urandom % 4 != 0);
      sel_n = ($urandom % 4 == 0);
      e_s = exp_sel(m, db_n, bsy_n, sel_n);
      e_p = exp_perr(m, db_n, dbp_n, bsy_n, sel_n, par_chk_en);
      cycles(7);
      check("R3 R4 random selection", sel_irq, e_s);
      check("R8 R9 random parity", par_err, e_p);
      pulse_clr(); cycles(6);
      check("R6 random no refire", sel_irq, 1'b0);
      idle_bus(); cycles(6);
    end
    summary();
  end
endmodule